// File: doc/BRIEF.md
# Module Clock and Reset State Controller

This block governs the clock enable and the reset of a single peripheral module. Software selects one of six operating states through a 3-bit code and commits it with a one-cycle go pulse. Each fixed state pairs a clock setting (on or off) with a reset setting (asserted or released). Two automatic states keep the clock gated until an internal bus access arrives. In the sleeping variant the clock is enabled only for the duration of each access. In the waking variant the first access turns the clock on for good.

A build-time strap marks modules that must never have their clock switched off by a fixed state. For such a module, a request that would stop the clock or hold reset is redirected to the fully running state. A separate local reset is driven by a software bit. When that bit is cleared, the local reset waits until the module reports no outstanding transactions before it asserts. It leaves the clock untouched. External events are acknowledged only while the module runs in the fully enabled state.

Top module: `mod_power_ctl`

## Requirements
- R1: After reset, curState reads 3 (running), clkEn=1, modRstN=1, transBusy=0 and the local reset is released.
- R2: State codes set the outputs as follows. Code 3 (running) gives clkEn=1, modRstN=1 and accGrant following accReq. Code 2 (gated) gives clkEn=0, modRstN=1. Code 1 (held in reset) gives clkEn=1, modRstN=0. Code 0 (gated and held) gives clkEn=0, modRstN=0. In codes 0 to 2, accGrant stays 0.
- R3: A requested code of 6 or 7 is taken as code 3.
- R4: A change of reqState without go has no effect. After go is sampled, transBusy is 1 for exactly one cycle. The new state and its outputs appear at the clock edge where transBusy returns to 0.
- R5: In auto-sleep (code 4), clkEn is 0 while idle. An accReq sampled at one edge raises clkEn at that edge, and accGrant rises one edge later.
- R6: In auto-sleep, accGrant falls at the edge where accDone is sampled, and clkEn falls at the following edge.
- R7: In auto-wake (code 5), clkEn is 0 until the first accReq. From the edge that samples it, clkEn stays 1 and accGrant follows accReq, even after accReq drops.
- R8: Leaving auto-wake and entering it again clears the wake, so clkEn returns to 0 until the next accReq.
- R9: extAck equals extEvent only in the running state (code 3). In every other state it is 0.
- R10: With AUTO_ONLY=1, request codes 0, 1 and 2 land in state 3. Codes 4 and 5 are accepted as given.
- R11: With lrstBit=0, modRstN falls at the first edge where txBusy is 0, and not before. With lrstBit=1 it rises at the next edge. The local reset never changes clkEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqState | input | 3 | Requested state code |
| go | input | 1 | Commit pulse for reqState |
| lrstBit | input | 1 | Local reset control, 0 asserts, 1 releases |
| accReq | input | 1 | Internal bus access request |
| accDone | input | 1 | Access serviced handshake |
| extEvent | input | 1 | External event / I/O request |
| txBusy | input | 1 | Module has outstanding transactions |
| clkEn | output | 1 | Module clock enable |
| modRstN | output | 1 | Module reset, active low |
| accGrant | output | 1 | Access granted to the module |
| extAck | output | 1 | External event acknowledged |
| curState | output | 3 | Current state code |
| transBusy | output | 1 | State transition in progress |

## Verification
A go pulse shows up as transBusy one edge later, and the new state one edge after that. In auto-sleep, clkEn is due one edge after accReq, accGrant one edge after that, and clkEn drops one edge after accDone. The local reset and the auto-wake latch react at the first edge that samples their input. Every stimulus is applied on a falling edge, and each output is read on the falling edge that follows the exact number of rising edges its requirement states. The bench therefore checks both the value and the cycle it appears in, along with the value just before that cycle.

// File: rtl/mod_power_pkg.sv
package mod_power_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_GATED_HELD = 3'd0,
    ST_HELD       = 3'd1,
    ST_GATED      = 3'd2,
    ST_RUN        = 3'd3,
    ST_AUTO_SLEEP = 3'd4,
    ST_AUTO_WAKE  = 3'd5
  } pstate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadState;
    pstate_e nextState;
    logic    sleepClk;
    logic    sleepGrant;
    logic    lrstAssert;
    logic    lrstRelease;
  } strobe_t;
endpackage

// File: rtl/mod_power_ctrl.sv
module mod_power_ctrl
  import mod_power_pkg::*;
#(
  parameter bit AUTO_ONLY = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATE_W-1:0]  reqState,
  input  logic                go,
  input  logic                lrstBit,
  input  logic                accReq,
  input  logic                accDone,
  input  logic                txBusy,
  input  pstate_e             curState,
  input  logic                localRstN,
  output strobe_t             strobe,
  output logic                transBusy
);
  typedef enum logic [1:0] {SP_IDLE, SP_WAKE, SP_GRANT, SP_DRAIN} sleep_e;

  pstate_e target;
  pstate_e pendState;
  logic    busyQ;
  sleep_e  sleepPhase;

  // request decode: out-of-range and strap-forbidden codes become running
  always_comb begin
    target = ST_RUN;
    case (reqState)
      3'd0, 3'd1, 3'd2: target = AUTO_ONLY ? ST_RUN : pstate_e'(reqState);
      3'd3, 3'd4, 3'd5: target = pstate_e'(reqState);
      default:          target = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      pendState <= ST_RUN;
    end else if (go && !busyQ) begin
      busyQ     <= 1'b1;
      pendState <= target;
    end else begin
      busyQ     <= 1'b0;
    end
  end

  // auto-sleep access sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepPhase <= SP_IDLE;
    end else if (busyQ || curState != ST_AUTO_SLEEP) begin
      sleepPhase <= SP_IDLE;
    end else begin
      case (sleepPhase)
        SP_IDLE:  if (accReq) sleepPhase <= SP_WAKE;
        SP_WAKE:  sleepPhase <= SP_GRANT;
        SP_GRANT: if (accDone) sleepPhase <= SP_DRAIN;
        default:  sleepPhase <= SP_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadState   = busyQ;
    strobe.nextState   = pendState;
    strobe.sleepClk    = (sleepPhase != SP_IDLE);
    strobe.sleepGrant  = (sleepPhase == SP_GRANT);
    strobe.lrstAssert  = !lrstBit && localRstN && !txBusy;
    strobe.lrstRelease = lrstBit && !localRstN;
  end

  assign transBusy = busyQ;

  // R4: a transition settles within one cycle
  assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    transBusy |=> !transBusy);

  // R5: grant is never presented without the sleep clock running
  assert_grant_has_clock_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sleepGrant |-> strobe.sleepClk);
endmodule

// File: rtl/mod_power_dp.sv
module mod_power_dp
  import mod_power_pkg::*;
#(
  parameter bit AUTO_ONLY = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  logic    accReq,
  input  logic    extEvent,
  input  logic    txBusy,
  output pstate_e curState,
  output logic    localRstN,
  output logic    clkEn,
  output logic    modRstN,
  output logic    accGrant,
  output logic    extAck
);
  logic awake;
  logic stateRstN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState  <= ST_RUN;
      awake     <= 1'b0;
      localRstN <= 1'b1;
    end else begin
      if (strobe.loadState) curState <= strobe.nextState;
      if (strobe.loadState) awake <= 1'b0;
      else if (curState == ST_AUTO_WAKE && accReq) awake <= 1'b1;
      if (strobe.lrstAssert) localRstN <= 1'b0;
      else if (strobe.lrstRelease) localRstN <= 1'b1;
    end
  end

  always_comb begin
    clkEn     = 1'b1;
    stateRstN = 1'b1;
    accGrant  = accReq;
    case (curState)
      ST_GATED_HELD: begin clkEn = 1'b0; stateRstN = 1'b0; accGrant = 1'b0; end
      ST_HELD:       begin clkEn = 1'b1; stateRstN = 1'b0; accGrant = 1'b0; end
      ST_GATED:      begin clkEn = 1'b0; accGrant = 1'b0; end
      ST_AUTO_SLEEP: begin clkEn = strobe.sleepClk; accGrant = strobe.sleepGrant; end
      ST_AUTO_WAKE:  begin clkEn = awake; accGrant = awake && accReq; end
      default:       begin clkEn = 1'b1; accGrant = accReq; end
    endcase
  end

  assign modRstN = stateRstN && localRstN;
  assign extAck  = extEvent && (curState == ST_RUN);

  // R9: a gated clock never acknowledges an external event
  assert_no_ext_when_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> !extAck);

  // R5: in auto-sleep the clock precedes the grant by a cycle
  assert_clock_before_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_AUTO_SLEEP && $rose(accGrant)) |-> $past(clkEn));

  // R7: once woken, auto-wake keeps the clock running
  assert_wake_holds_clock_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_AUTO_WAKE && awake) |-> clkEn);

  // R11: local reset asserts only when no transaction was outstanding
  assert_lrst_drained_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(localRstN) |-> $past(!txBusy));

  generate
    if (AUTO_ONLY) begin : g_strap
      // R10: strapped module never sits in a gated or held state
      assert_strap_states_R10: assert property (@(posedge clk) disable iff (!rstN)
        curState inside {ST_RUN, ST_AUTO_SLEEP, ST_AUTO_WAKE});
    end
  endgenerate
endmodule

// File: rtl/mod_power_ctl.sv
module mod_power_ctl
  import mod_power_pkg::*;
#(
  parameter bit AUTO_ONLY = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] reqState,
  input  logic               go,
  input  logic               lrstBit,
  input  logic               accReq,
  input  logic               accDone,
  input  logic               extEvent,
  input  logic               txBusy,
  output logic               clkEn,
  output logic               modRstN,
  output logic               accGrant,
  output logic               extAck,
  output logic [STATE_W-1:0] curState,
  output logic               transBusy
);
  strobe_t strobe;
  pstate_e stateQ;
  logic    localRstN;

  mod_power_ctrl #(.AUTO_ONLY(AUTO_ONLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqState(reqState), .go(go), .lrstBit(lrstBit),
    .accReq(accReq), .accDone(accDone), .txBusy(txBusy), .curState(stateQ),
    .localRstN(localRstN), .strobe(strobe), .transBusy(transBusy)
  );

  mod_power_dp #(.AUTO_ONLY(AUTO_ONLY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accReq(accReq), .extEvent(extEvent),
    .txBusy(txBusy), .curState(stateQ), .localRstN(localRstN), .clkEn(clkEn),
    .modRstN(modRstN), .accGrant(accGrant), .extAck(extAck)
  );

  assign curState = stateQ;
endmodule

// File: tb/mod_power_ctl_tb.sv
module mod_power_ctl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] reqState = 3'd3;
  logic go = 1'b0, lrstBit = 1'b1, accReq = 1'b0, accDone = 1'b0;
  logic extEvent = 1'b0, txBusy = 1'b0;
  logic clkEn, modRstN, accGrant, extAck, transBusy;
  logic [2:0] curState;
  logic sClkEn, sModRstN, sAccGrant, sExtAck, sTransBusy;
  logic [2:0] sCurState;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mod_power_ctl #(.AUTO_ONLY(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .reqState(reqState), .go(go), .lrstBit(lrstBit),
    .accReq(accReq), .accDone(accDone), .extEvent(extEvent), .txBusy(txBusy),
    .clkEn(clkEn), .modRstN(modRstN), .accGrant(accGrant), .extAck(extAck),
    .curState(curState), .transBusy(transBusy));

  mod_power_ctl #(.AUTO_ONLY(1'b1)) u_dut_strap (
    .clk(clk), .rstN(rstN), .reqState(reqState), .go(go), .lrstBit(lrstBit),
    .accReq(accReq), .accDone(accDone), .extEvent(extEvent), .txBusy(txBusy),
    .clkEn(sClkEn), .modRstN(sModRstN), .accGrant(sAccGrant), .extAck(sExtAck),
    .curState(sCurState), .transBusy(sTransBusy));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic program_state(input logic [2:0] code);
    reqState = code; go = 1'b1;
    tick(1);
    go = 1'b0;
    tick(1);
  endtask

  task automatic t_reset;
    chk("R1", "curState", curState, 3);
    chk("R1", "clkEn", clkEn, 1);
    chk("R1", "modRstN", modRstN, 1);
    chk("R1", "transBusy", transBusy, 0);
  endtask

  task automatic t_go_timing;
    reqState = 3'd2;
    tick(3);
    chk("R4", "no go curState", curState, 3);
    chk("R4", "no go clkEn", clkEn, 1);
    go = 1'b1;
    tick(1);
    go = 1'b0;
    chk("R4", "busy after go", transBusy, 1);
    chk("R4", "old state while busy", curState, 3);
    tick(1);
    chk("R4", "busy cleared", transBusy, 0);
    chk("R4", "new state", curState, 2);
  endtask

  task automatic t_fixed_states;
    program_state(3'd2);
    accReq = 1'b1; #1;
    chk("R2", "gated clkEn", clkEn, 0);
    chk("R2", "gated modRstN", modRstN, 1);
    chk("R2", "gated grant", accGrant, 0);
    program_state(3'd1);
    chk("R2", "held clkEn", clkEn, 1);
    chk("R2", "held modRstN", modRstN, 0);
    chk("R2", "held grant", accGrant, 0);
    program_state(3'd0);
    chk("R2", "gated-held clkEn", clkEn, 0);
    chk("R2", "gated-held modRstN", modRstN, 0);
    program_state(3'd3);
    chk("R2", "run clkEn", clkEn, 1);
    chk("R2", "run modRstN", modRstN, 1);
    chk("R2", "run grant", accGrant, 1);
    accReq = 1'b0; #1;
    chk("R2", "run grant follows", accGrant, 0);
  endtask

  task automatic t_invalid;
    program_state(3'd2);
    program_state(3'd6);
    chk("R3", "code 6", curState, 3);
    program_state(3'd2);
    program_state(3'd7);
    chk("R3", "code 7", curState, 3);
    chk("R3", "code 7 clkEn", clkEn, 1);
  endtask

  task automatic t_auto_sleep;
    program_state(3'd4);
    chk("R5", "idle clkEn", clkEn, 0);
    accReq = 1'b1;
    tick(1);
    chk("R5", "clk on", clkEn, 1);
    chk("R5", "grant not yet", accGrant, 0);
    tick(1);
    chk("R5", "grant up", accGrant, 1);
    accReq = 1'b0;
    tick(2);
    chk("R6", "grant holds", accGrant, 1);
    accDone = 1'b1;
    tick(1);
    accDone = 1'b0;
    chk("R6", "grant down", accGrant, 0);
    chk("R6", "clk still on", clkEn, 1);
    tick(1);
    chk("R6", "clk off", clkEn, 0);
    tick(2);
    chk("R6", "stays off", clkEn, 0);
  endtask

  task automatic t_auto_wake;
    program_state(3'd5);
    tick(2);
    chk("R7", "asleep", clkEn, 0);
    accReq = 1'b1;
    tick(1);
    chk("R7", "woken", clkEn, 1);
    chk("R7", "grant", accGrant, 1);
    accReq = 1'b0;
    tick(3);
    chk("R7", "stays on", clkEn, 1);
    chk("R7", "grant follows", accGrant, 0);
    program_state(3'd3);
    program_state(3'd5);
    chk("R8", "re-entry asleep", clkEn, 0);
    tick(2);
    chk("R8", "still asleep", clkEn, 0);
    accReq = 1'b1;
    tick(1);
    accReq = 1'b0;
    chk("R8", "wakes again", clkEn, 1);
  endtask

  task automatic t_ext;
    program_state(3'd3);
    extEvent = 1'b1; #1;
    chk("R9", "run ack", extAck, 1);
    program_state(3'd2);
    chk("R9", "gated ack", extAck, 0);
    chk("R9", "gated clk", clkEn, 0);
    program_state(3'd4);
    chk("R9", "auto-sleep ack", extAck, 0);
    chk("R9", "auto-sleep clk", clkEn, 0);
    program_state(3'd1);
    chk("R9", "held ack", extAck, 0);
    extEvent = 1'b0;
    program_state(3'd3);
  endtask

  task automatic t_local_reset;
    txBusy = 1'b1; lrstBit = 1'b0;
    tick(3);
    chk("R11", "waits for drain", modRstN, 1);
    txBusy = 1'b0;
    tick(1);
    chk("R11", "asserted", modRstN, 0);
    chk("R11", "clock untouched", clkEn, 1);
    lrstBit = 1'b1;
    tick(1);
    chk("R11", "released", modRstN, 1);
    chk("R11", "clock still on", clkEn, 1);
  endtask

  task automatic t_strap;
    program_state(3'd1);
    chk("R10", "plain takes held", curState, 1);
    chk("R10", "strap held->run", sCurState, 3);
    chk("R10", "strap clkEn", sClkEn, 1);
    chk("R10", "strap modRstN", sModRstN, 1);
    program_state(3'd2);
    chk("R10", "strap gated->run", sCurState, 3);
    program_state(3'd0);
    chk("R10", "strap gated-held->run", sCurState, 3);
    program_state(3'd4);
    chk("R10", "strap auto-sleep", sCurState, 4);
    program_state(3'd5);
    chk("R10", "strap auto-wake", sCurState, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_go_timing();
    t_fixed_states();
    t_invalid();
    t_auto_sleep();
    t_auto_wake();
    t_ext();
    t_local_reset();
    t_strap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule